// File: doc/BRIEF.md
# Line Sensor Framing and Black-Level Extraction

This block sits behind the converter of a 3000-pixel linear image sensor. It takes one digitized sample per pixel strobe (`smp_valid`) and a line-start marker that travels with the first sample of each line. A position counter places every sample of the 3066-position line into one of four classes: leading dummy, shielded (optical black), effective, or trailing dummy. Only the 3000 effective samples reach the output stream, in order, with markers on the first and last of them. Dummy and black positions never reach that stream.

Over the 30 shielded positions the block adds up the even-indexed and odd-indexed samples in two full-width sums. Each sum is divided by 15 in a small sequential divider. When a line closes, the block reports both black levels in a one-cycle publish pulse, together with a length-error flag and a flag that says whether the levels can be trusted. A line closes either when the next line-start arrives or when a 3067th sample arrives without one. A small FIFO on the pixel stream absorbs back-pressure. If a sample arrives while the FIFO is full and nothing is leaving, the sample is dropped and a sticky overflow flag is raised.

Top module: `ccd_line_framer`

## Requirements
- R1: After reset, `pix_valid`, `blk_valid`, `line_err` and `ovf_err` are all 0.
- R2: A sample is taken only when `smp_valid` is 1. Line positions are counted from 0 at the sample that carries `line_start`. Exactly positions 56 to 3055 appear on the pixel stream, in arrival order and with unchanged values. Positions 0 to 55 and 3056 to 3065 never appear.
- R3: `pix_first` is 1 only on the pixel from position 56, and `pix_last` is 1 only on the pixel from position 3055.
- R4: `blk_even` is the floor of the sum of the samples at positions 24, 26, …, 52 divided by 15. `blk_odd` is the same quantity for positions 25, 27, …, 53.
- R5: The black-level sums keep full width, so 15 full-scale samples (4095) give a level of exactly 4095.
- R6: Each line that closes produces exactly one `blk_valid` pulse. A line closes either when a new `line_start` sample arrives or when a 3067th sample arrives without one.
- R7: A line is too short when it is closed by `line_start` after fewer than 3066 samples. For such a line the publish pulse carries `line_err`=1 and `blk_ok`=0. A line of exactly 3066 samples carries `line_err`=0 and `blk_ok`=1.
- R8: When a 3067th sample arrives without `line_start`, that sample is discarded and the line is published with `line_err`=1 and `blk_ok`=0. All further samples are ignored until the next `line_start`, and that `line_start` publishes nothing.
- R9: Samples that arrive before the first `line_start` after reset produce no pixel and no publish pulse.
- R10: While `pix_ready` is 0, up to 4 pixels are held without loss. `pix_valid` and `pix_data` stay stable until they are accepted.
- R11: An effective sample that arrives while the FIFO holds 4 pixels and none leaves in that cycle is dropped. It sets `ovf_err`, which stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Pixel strobe: `smp_data` holds one sample |
| line_start | input | 1 | Marks the strobed sample as position 0 of a new line |
| smp_data | input | 12 | Digitized sample |
| pix_valid | output | 1 | Effective pixel available |
| pix_ready | input | 1 | Downstream accepts the pixel |
| pix_data | output | 12 | Effective pixel value |
| pix_first | output | 1 | Pixel is the first effective one of the line |
| pix_last | output | 1 | Pixel is the last effective one of the line |
| blk_valid | output | 1 | One-cycle publish pulse when a line closes |
| blk_ok | output | 1 | Black levels of the closed line are valid |
| line_err | output | 1 | Closed line had the wrong length |
| blk_even | output | 12 | Even-position black level |
| blk_odd | output | 12 | Odd-position black level |
| ovf_err | output | 1 | Sticky pixel FIFO overflow |

## Verification
Two events can fall in the same clock. The first is the close of one line and the start of the next: the `line_start` sample both publishes the old line's levels and clears the level-ready state for the new line. The bench provokes this by driving back-to-back lines, with no idle cycles and with gaps, and judges that each publish carries the closed line's own levels and length verdict. The second is a FIFO push that arrives while the FIFO is full and a pop happens in the same cycle. This is provoked by toggling `pix_ready` during a sparse line and by holding it low through a whole line. The reference queue judges both cases: it expects no loss in the first case and exactly the first four pixels in the second.

// File: rtl/ccd_frm_pkg.sv
package ccd_frm_pkg;

    localparam int DEF_SAMPLE_W   = 12;
    localparam int DEF_LINE_LEN   = 3066;
    localparam int DEF_LEAD_LEN   = 56;
    localparam int DEF_ACTIVE_LEN = 3000;
    localparam int DEF_OB_START   = 24;
    localparam int DEF_OB_LEN     = 30;
    localparam int DEF_FIFO_DEPTH = 4;

    typedef enum logic [1:0] {
        PC_LEAD   = 2'd0,
        PC_BLACK  = 2'd1,
        PC_ACTIVE = 2'd2,
        PC_TRAIL  = 2'd3
    } pos_class_e;

    typedef struct packed {
        logic first;
        logic last;
    } pix_mark_t;

    function automatic pos_class_e classify(input int idx, input int lead_len,
                                            input int ob_start, input int ob_len,
                                            input int active_len);
        if (idx < ob_start)                       return PC_LEAD;
        else if (idx < ob_start + ob_len)         return PC_BLACK;
        else if (idx < lead_len)                  return PC_LEAD;
        else if (idx < lead_len + active_len)     return PC_ACTIVE;
        else                                      return PC_TRAIL;
    endfunction

endpackage

// File: rtl/ccd_seq_div.sv
// Restoring divider by a constant: one quotient bit per cycle.
module ccd_seq_div #(
    parameter int NUM_W   = 16,
    parameter int DIVISOR = 15,
    parameter int QUO_W   = 12,
    localparam int DEN_W  = $clog2(DIVISOR + 1),
    localparam int CNT_W  = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] dividend,
    output logic [QUO_W-1:0] quotient,
    output logic             done
);
    localparam logic [DEN_W:0]   DIV_C = (DEN_W + 1)'(DIVISOR);
    localparam logic [CNT_W-1:0] STEPS = CNT_W'(NUM_W);

    logic [NUM_W-1:0] num_q;
    logic [DEN_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic [DEN_W:0]   trial;
    logic             ge;
    logic [DEN_W-1:0] nrem;

    always_comb begin
        trial = {rem_q, num_q[NUM_W-1]};
        ge    = (trial >= DIV_C);
        nrem  = ge ? DEN_W'(trial - DIV_C) : trial[DEN_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                num_q  <= dividend;
                rem_q  <= '0;
                cnt_q  <= STEPS;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= nrem;
                num_q <= {num_q[NUM_W-2:0], ge};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign quotient = num_q[QUO_W-1:0];

    // R4: a mean of samples never exceeds the sample range
    p_quo_fits_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (num_q[NUM_W-1:QUO_W] == '0));

    // R4: completion is a single-cycle event
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/ccd_pos_tracker.sv
// Counts line positions, tags each sample with its class, detects line closure.
module ccd_pos_tracker
    import ccd_frm_pkg::*;
#(
    parameter int SAMPLE_W   = DEF_SAMPLE_W,
    parameter int LINE_LEN   = DEF_LINE_LEN,
    parameter int LEAD_LEN   = DEF_LEAD_LEN,
    parameter int ACTIVE_LEN = DEF_ACTIVE_LEN,
    parameter int OB_START   = DEF_OB_START,
    parameter int OB_LEN     = DEF_OB_LEN,
    localparam int POS_W     = $clog2(LINE_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic                line_start,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                tag_valid,
    output logic [POS_W-1:0]    tag_idx,
    output pos_class_e          tag_cls,
    output logic [SAMPLE_W-1:0] tag_data,
    output logic                close_valid,
    output logic                close_len_ok
);
    localparam logic [POS_W-1:0] LEN_C = POS_W'(LINE_LEN);

    logic [POS_W-1:0] pos_q;
    logic             in_line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q        <= '0;
            in_line_q    <= 1'b0;
            tag_valid    <= 1'b0;
            tag_idx      <= '0;
            tag_cls      <= PC_LEAD;
            tag_data     <= '0;
            close_valid  <= 1'b0;
            close_len_ok <= 1'b0;
        end else begin
            tag_valid    <= 1'b0;
            close_valid  <= 1'b0;
            close_len_ok <= 1'b0;
            if (smp_valid) begin
                if (line_start) begin
                    close_valid  <= in_line_q;
                    close_len_ok <= (pos_q == LEN_C);
                    in_line_q    <= 1'b1;
                    pos_q        <= POS_W'(1);
                    tag_valid    <= 1'b1;
                    tag_idx      <= '0;
                    tag_cls      <= classify(0, LEAD_LEN, OB_START, OB_LEN, ACTIVE_LEN);
                    tag_data     <= smp_data;
                end else if (in_line_q) begin
                    if (pos_q == LEN_C) begin
                        close_valid <= 1'b1;
                        in_line_q   <= 1'b0;
                    end else begin
                        tag_valid <= 1'b1;
                        tag_idx   <= pos_q;
                        tag_cls   <= classify(int'(pos_q), LEAD_LEN, OB_START, OB_LEN, ACTIVE_LEN);
                        tag_data  <= smp_data;
                        pos_q     <= pos_q + 1'b1;
                    end
                end
            end
        end
    end

    // R8: the position counter never runs past one line
    p_pos_bound_r8: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LEN_C);

    // R8: no tagged sample lies beyond the last line position
    p_tag_in_line_r8: assert property (@(posedge clk) disable iff (rst)
        tag_valid |-> (tag_idx < LEN_C));

endmodule

// File: rtl/ccd_black_acc.sv
// Even/odd sums over the shielded window and their division by the sample count.
module ccd_black_acc
    import ccd_frm_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int OB_START = DEF_OB_START,
    parameter int OB_LEN   = DEF_OB_LEN,
    parameter int POS_W    = 12,
    localparam int PAR_CNT = OB_LEN / 2,
    localparam int SUM_W   = SAMPLE_W + $clog2(PAR_CNT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tag_valid,
    input  logic [POS_W-1:0]    tag_idx,
    input  pos_class_e          tag_cls,
    input  logic [SAMPLE_W-1:0] tag_data,
    output logic [SAMPLE_W-1:0] lvl_even,
    output logic [SAMPLE_W-1:0] lvl_odd,
    output logic                lvl_ready
);
    localparam logic [POS_W-1:0] FIRST_PAIR_END = POS_W'(OB_START + 2);
    localparam logic [POS_W-1:0] OB_LAST        = POS_W'(OB_START + OB_LEN - 1);

    logic [SUM_W-1:0]    sum_q  [2];
    logic [SAMPLE_W-1:0] quo    [2];
    logic [SAMPLE_W-1:0] lvl_q  [2];
    logic                done   [2];
    logic                div_go;

    always_ff @(posedge clk) begin
        if (rst) div_go <= 1'b0;
        else     div_go <= tag_valid && (tag_idx == OB_LAST);
    end

    for (genvar g = 0; g < 2; g++) begin : g_par
        always_ff @(posedge clk) begin
            if (rst) begin
                sum_q[g] <= '0;
            end else if (tag_valid && tag_cls == PC_BLACK && tag_idx[0] == 1'(g)) begin
                if (tag_idx < FIRST_PAIR_END)
                    sum_q[g] <= SUM_W'(tag_data);
                else
                    sum_q[g] <= sum_q[g] + SUM_W'(tag_data);
            end
        end

        ccd_seq_div #(
            .NUM_W   (SUM_W),
            .DIVISOR (PAR_CNT),
            .QUO_W   (SAMPLE_W)
        ) u_div (
            .clk      (clk),
            .rst      (rst),
            .start    (div_go),
            .dividend (sum_q[g]),
            .quotient (quo[g]),
            .done     (done[g])
        );

        always_ff @(posedge clk) begin
            if (rst)          lvl_q[g] <= '0;
            else if (done[g]) lvl_q[g] <= quo[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                lvl_ready <= 1'b0;
        else if (tag_valid && tag_idx == '0)    lvl_ready <= 1'b0;
        else if (done[0])                       lvl_ready <= 1'b1;
    end

    assign lvl_even = lvl_q[0];
    assign lvl_odd  = lvl_q[1];

    // R4: both parities finish together
    p_div_lockstep_r4: assert property (@(posedge clk) disable iff (rst)
        done[0] == done[1]);

endmodule

// File: rtl/ccd_pix_fifo.sv
// Small FIFO for the effective pixel stream, with sticky overflow.
module ccd_pix_fifo #(
    parameter int W     = 14,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         ovf_err
);
    localparam logic [PTR_W:0]   FULL_C = (PTR_W + 1)'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [PTR_W:0]   cnt_q;
    logic             do_pop, do_push, full;

    always_comb begin
        full      = (cnt_q == FULL_C);
        out_valid = (cnt_q != '0);
        do_pop    = out_valid && out_ready;
        do_push   = push && (!full || do_pop);
        out_data  = mem[rd_q];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= '0;
            rd_q    <= '0;
            cnt_q   <= '0;
            ovf_err <= 1'b0;
        end else begin
            if (do_push) wr_q <= (wr_q == LAST_P) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == LAST_P) ? '0 : rd_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
            if (push && !do_push) ovf_err <= 1'b1;
        end
    end

    // R10: a stalled pixel is held unchanged
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R11: overflow is sticky
    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err);

    // R11: occupancy bounded by the depth
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_C);

endmodule

// File: rtl/ccd_line_framer.sv
module ccd_line_framer
    import ccd_frm_pkg::*;
#(
    parameter int SAMPLE_W   = DEF_SAMPLE_W,
    parameter int LINE_LEN   = DEF_LINE_LEN,
    parameter int LEAD_LEN   = DEF_LEAD_LEN,
    parameter int ACTIVE_LEN = DEF_ACTIVE_LEN,
    parameter int OB_START   = DEF_OB_START,
    parameter int OB_LEN     = DEF_OB_LEN,
    parameter int FIFO_DEPTH = DEF_FIFO_DEPTH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic                line_start,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                pix_valid,
    input  logic                pix_ready,
    output logic [SAMPLE_W-1:0] pix_data,
    output logic                pix_first,
    output logic                pix_last,
    output logic                blk_valid,
    output logic                blk_ok,
    output logic                line_err,
    output logic [SAMPLE_W-1:0] blk_even,
    output logic [SAMPLE_W-1:0] blk_odd,
    output logic                ovf_err
);
    localparam int POS_W  = $clog2(LINE_LEN + 1);
    localparam int FIFO_W = SAMPLE_W + $bits(pix_mark_t);
    localparam logic [POS_W-1:0] FIRST_IDX = POS_W'(LEAD_LEN);
    localparam logic [POS_W-1:0] LAST_IDX  = POS_W'(LEAD_LEN + ACTIVE_LEN - 1);

    logic                tag_valid;
    logic [POS_W-1:0]    tag_idx;
    pos_class_e          tag_cls;
    logic [SAMPLE_W-1:0] tag_data;
    logic                close_valid, close_len_ok;
    logic [SAMPLE_W-1:0] lvl_even, lvl_odd;
    logic                lvl_ready;
    logic                fifo_push;
    pix_mark_t           in_mark, out_mark;
    logic [FIFO_W-1:0]   fifo_in, fifo_out;

    ccd_pos_tracker #(
        .SAMPLE_W   (SAMPLE_W),
        .LINE_LEN   (LINE_LEN),
        .LEAD_LEN   (LEAD_LEN),
        .ACTIVE_LEN (ACTIVE_LEN),
        .OB_START   (OB_START),
        .OB_LEN     (OB_LEN)
    ) u_trk (
        .clk          (clk),
        .rst          (rst),
        .smp_valid    (smp_valid),
        .line_start   (line_start),
        .smp_data     (smp_data),
        .tag_valid    (tag_valid),
        .tag_idx      (tag_idx),
        .tag_cls      (tag_cls),
        .tag_data     (tag_data),
        .close_valid  (close_valid),
        .close_len_ok (close_len_ok)
    );

    ccd_black_acc #(
        .SAMPLE_W (SAMPLE_W),
        .OB_START (OB_START),
        .OB_LEN   (OB_LEN),
        .POS_W    (POS_W)
    ) u_blk (
        .clk       (clk),
        .rst       (rst),
        .tag_valid (tag_valid),
        .tag_idx   (tag_idx),
        .tag_cls   (tag_cls),
        .tag_data  (tag_data),
        .lvl_even  (lvl_even),
        .lvl_odd   (lvl_odd),
        .lvl_ready (lvl_ready)
    );

    always_comb begin
        fifo_push     = tag_valid && (tag_cls == PC_ACTIVE);
        in_mark.first = (tag_idx == FIRST_IDX);
        in_mark.last  = (tag_idx == LAST_IDX);
        fifo_in       = {in_mark, tag_data};
    end

    ccd_pix_fifo #(
        .W     (FIFO_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (fifo_push),
        .push_data (fifo_in),
        .out_ready (pix_ready),
        .out_valid (pix_valid),
        .out_data  (fifo_out),
        .ovf_err   (ovf_err)
    );

    always_comb begin
        out_mark  = fifo_out[FIFO_W-1:SAMPLE_W];
        pix_data  = fifo_out[SAMPLE_W-1:0];
        pix_first = out_mark.first;
        pix_last  = out_mark.last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_valid <= 1'b0;
            blk_ok    <= 1'b0;
            line_err  <= 1'b0;
            blk_even  <= '0;
            blk_odd   <= '0;
        end else begin
            blk_valid <= close_valid;
            if (close_valid) begin
                line_err <= !close_len_ok;
                blk_ok   <= close_len_ok && lvl_ready;
                blk_even <= lvl_even;
                blk_odd  <= lvl_odd;
            end
        end
    end

    // R7: a length error never comes with trusted levels
    p_err_blocks_ok_r7: assert property (@(posedge clk) disable iff (rst)
        (blk_valid && line_err) |-> !blk_ok);

    // R3: a pixel cannot be both first and last
    p_first_last_r3: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> !(pix_first && pix_last));

endmodule

// File: tb/ccd_line_framer_test.sv
module ccd_line_framer_test;
    localparam int SW    = 12;
    localparam int LLEN  = 3066;
    localparam int FIRST = 56;
    localparam int LAST  = 3055;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0, line_start = 1'b0, pix_ready = 1'b1;
    logic [SW-1:0] smp_data = '0;
    logic pix_valid, pix_first, pix_last, blk_valid, blk_ok, line_err, ovf_err;
    logic [SW-1:0] pix_data, blk_even, blk_odd;

    always #5 clk = ~clk;

    ccd_line_framer uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .line_start(line_start),
        .smp_data(smp_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_data(pix_data), .pix_first(pix_first), .pix_last(pix_last),
        .blk_valid(blk_valid), .blk_ok(blk_ok), .line_err(line_err),
        .blk_even(blk_even), .blk_odd(blk_odd), .ovf_err(ovf_err)
    );

    int checks = 0, errors = 0;
    int pix_q[$];
    int pub_q[$];
    int ready_mode = 0;
    int stall_budget = -1;
    int cyc = 0;
    bit m_in_line = 0;
    int m_cnt = 0, m_even = 0, m_odd = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // publish record: bit0 err, bits 1..12 even, bits 13..24 odd
    task automatic model_close(input bit err);
        pub_q.push_back(int'(err) | ((m_even / 15) << 1) | ((m_odd / 15) << 13));
    endtask

    task automatic model_sample(input bit ls, input int d);
        if (ls) begin
            if (m_in_line) model_close(m_cnt != LLEN);
            m_in_line = 1; m_cnt = 0; m_even = 0; m_odd = 0;
        end else if (m_in_line && m_cnt == LLEN) begin
            model_close(1'b1);
            m_in_line = 0;
            return;
        end
        if (!m_in_line) return;
        if (m_cnt >= 24 && m_cnt <= 53) begin
            if (m_cnt % 2 == 0) m_even += d; else m_odd += d;
        end
        if (m_cnt >= FIRST && m_cnt <= LAST) begin
            if (stall_budget != 0) begin
                pix_q.push_back(d | (int'(m_cnt == FIRST) << 16) | (int'(m_cnt == LAST) << 17));
                if (stall_budget > 0) stall_budget--;
            end
        end
        m_cnt++;
    endtask

    task automatic drive(input bit ls, input int d);
        @(negedge clk);
        smp_valid = 1'b1; line_start = ls; smp_data = SW'(d);
        model_sample(ls, d);
        @(negedge clk);
        smp_valid = 1'b0; line_start = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int pat(input int k, input int id, input bit ob_max);
        if (ob_max && k >= 24 && k <= 53) return 4095;
        return (k * 37 + id * 211 + (k >> 3) * 5) % 4096;
    endfunction

    // drive n samples, first one carries line_start when with_start
    task automatic run_line(input int n, input int gap, input int id,
                            input bit ob_max, input bit with_start);
        for (int k = 0; k < n; k++) begin
            drive(with_start && k == 0, pat(k, id, ob_max));
            if (gap > 0) idle(gap);
        end
    endtask

    // cycle-by-cycle monitor: ready pattern, pixel and publish comparison
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            case (ready_mode)
                0: pix_ready = 1'b1;
                1: pix_ready = ((cyc / 6) % 2) == 0;
                default: pix_ready = 1'b0;
            endcase
            if (!rst && pix_valid && pix_ready) begin
                if (pix_q.size() == 0) begin
                    check(0, "R2/R9 unexpected pixel", int'(pix_data), -1);
                end else begin
                    int e;
                    e = pix_q.pop_front();
                    check(int'(pix_data) == (e & 4095), "R2 pixel value", int'(pix_data), e & 4095);
                    check(pix_first == e[16], "R3 first marker", int'(pix_first), int'(e[16]));
                    check(pix_last == e[17], "R3 last marker", int'(pix_last), int'(e[17]));
                end
            end
            if (!rst && blk_valid) begin
                if (pub_q.size() == 0) begin
                    check(0, "R6/R9 unexpected publish", 1, 0);
                end else begin
                    int e, ev, od;
                    e = pub_q.pop_front();
                    ev = (e >> 1) & 4095;
                    od = (e >> 13) & 4095;
                    check(line_err == e[0], "R7/R8 line_err", int'(line_err), int'(e[0]));
                    check(blk_ok == !e[0], "R7/R8 blk_ok", int'(blk_ok), int'(!e[0]));
                    if (!e[0]) begin
                        check(int'(blk_even) == ev, ev == 4095 ? "R5 even level" : "R4 even level", int'(blk_even), ev);
                        check(int'(blk_odd) == od, od == 4095 ? "R5 odd level" : "R4 odd level", int'(blk_odd), od);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(pix_valid == 0, "R1 pix_valid", int'(pix_valid), 0);
        check(blk_valid == 0, "R1 blk_valid", int'(blk_valid), 0);
        check(line_err == 0, "R1 line_err", int'(line_err), 0);
        check(ovf_err == 0, "R1 ovf_err", int'(ovf_err), 0);

        // R9: samples before any line_start
        run_line(10, 0, 9, 0, 0);
        idle(10);
        check(pix_valid == 0, "R9 no pixel before line_start", int'(pix_valid), 0);

        // dense line, ready high (R2, R3, R4)
        ready_mode = 0;
        run_line(LLEN, 0, 1, 0, 1);
        // sparse line with toggling ready (R10); its start closes the previous line
        ready_mode = 1;
        run_line(LLEN, 2, 2, 0, 1);
        // full-scale black (R5)
        ready_mode = 0;
        run_line(LLEN, 0, 3, 1, 1);
        check(ovf_err == 0, "R10 no loss under stall", int'(ovf_err), 0);
        // short line (R7)
        run_line(1000, 0, 4, 0, 1);
        // over-long line (R8): 3067th sample closes it, extras ignored
        run_line(LLEN + 5, 0, 5, 0, 1);
        idle(30);
        check(pix_valid == 0, "R8 samples ignored after overrun", int'(pix_valid), 0);
        check(pub_q.size() == 0, "R8 overrun publish seen", pub_q.size(), 0);
        // new line after overrun: its start publishes nothing
        run_line(LLEN, 0, 6, 0, 1);
        idle(20);
        // overflow line (R11): ready low, only DEPTH pixels survive
        ready_mode = 2;
        stall_budget = DEPTH;
        run_line(LLEN, 0, 7, 0, 1);
        drive(1'b1, 5);
        idle(30);
        check(ovf_err == 1, "R11 overflow flag", int'(ovf_err), 1);
        ready_mode = 0;
        stall_budget = -1;
        idle(20);
        check(ovf_err == 1, "R11 overflow sticky", int'(ovf_err), 1);
        check(pix_q.size() == 0, "R10 queued pixels delivered", pix_q.size(), 0);
        check(pub_q.size() == 0, "R6 all publishes seen", pub_q.size(), 0);

        // reset clears sticky overflow (R1, R11)
        @(negedge clk);
        rst = 1'b1;
        m_in_line = 0;
        idle(2);
        rst = 1'b0;
        @(negedge clk);
        check(ovf_err == 0, "R11 cleared by reset", int'(ovf_err), 0);
        check(pix_valid == 0, "R1 pix_valid after reset", int'(pix_valid), 0);

        summary();
        $finish;
    end

endmodule